// File: doc/BRIEF.md
# PHY Power-Up Lock Sequencer

This controller brings a serial display PHY and its PLL through configuration, power-up and power-down. Each of its power-down lines is active low: a 0 powers the section up and a 1 powers it down.

A configuration command powers everything down and holds the external reset request. It then emits one-cycle load strobes for the timing registers, the lock-bypass clear and the test register, with the test value 0x25 on its own output. Last, it checks the divider triple and latches it only when all three values are in range.

A power-up command releases the PLL power-down. It then samples the lock flag once every `TICKS_PER_POLL` microsecond ticks, for at most `MAX_POLLS` samples. When lock is seen, the PHY power-down is released first and the reset request one cycle after that. If lock never arrives, the PLL is powered down again and an error pulse is raised. A power-down command and a clear command each finish in a single cycle.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `pll_pd` and `phy_pd` are 1, `rst_release`, `busy`, `done` and `err` are 0, and `cm_code`, `cn_code`, `co_code` and `attempts` are 0.
- R2: A configuration command accepted at edge E sets both power-downs to 1 and `rst_release` to 0 after E. `ld_timing` is then high in the cycle after E, `ld_bypass_clr` in the next cycle and `ld_test` in the cycle after that, each for exactly one cycle, and `test_value` is always 0x25.
- R3: In the fourth cycle after a configuration command, the divider is checked. It is valid when `cm_in` is in 16..255, `cn_in` in 1..32 and `co_in` in 1..8. If valid, `ld_div` is high in that cycle and the codes take the inputs with a one-cycle `done` pulse. If not, `ld_div` stays low, the codes keep their old values and `err` pulses for one cycle.
- R4: A power-up command clears `pll_pd` after the accepting edge and resets `attempts` to 0. One lock sample is taken on every `TICKS_PER_POLL`-th `us_tick` after that, and each sample increments `attempts`.
- R5: If `MAX_POLLS` samples all see `pll_lock` low, `pll_pd` returns to 1 after the last sample and `err` pulses once. `phy_pd` stays 1 throughout.
- R6: When a sample sees `pll_lock` high, `phy_pd` goes to 0 after that edge. One cycle later, `rst_release` goes to 1 and `done` pulses once.
- R7: A power-down command in idle sets both power-downs to 1 and `rst_release` to 0, and pulses `done`, all in the cycle after the command.
- R8: A clear command in idle sets `cm_code`, `cn_code` and `co_code` to 0 and pulses `done`.
- R9: `busy` is high from the cycle after a configuration or power-up command until the sequence ends. Any command arriving while `busy` is high has no effect.
- R10: When several commands arrive together in idle, only one is taken, in this priority: power-down, then configuration, then power-up, then clear.
- R11: `attempts` holds the number of lock samples used by the latest power-up, never exceeds `MAX_POLLS`, and equals 1 when lock is already present at the first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cmd_init | input | 1 | Configuration command |
| cmd_on | input | 1 | Power-up command |
| cmd_off | input | 1 | Power-down command |
| cmd_exit | input | 1 | Clear divider codes command |
| pll_lock | input | 1 | PLL lock flag |
| cm_in | input | CM_W | Feedback multiplier value |
| cn_in | input | CN_W | Input divider value |
| co_in | input | CO_W | Output divider value |
| pll_pd | output | 1 | PLL power-down, 1 = off |
| phy_pd | output | 1 | PHY power-down, 1 = off |
| rst_release | output | 1 | External reset release request |
| ld_timing | output | 1 | Timing register load strobe |
| ld_bypass_clr | output | 1 | Lock-bypass clear strobe |
| ld_test | output | 1 | Test register load strobe |
| test_value | output | 8 | Value for the test register |
| ld_div | output | 1 | Divider register load strobe |
| cm_code | output | CM_W | Latched multiplier |
| cn_code | output | CN_W | Latched input divider |
| co_code | output | CO_W | Latched output divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| attempts | output | AW | Lock samples used |

## Verification
The assertions check power ordering on every cycle. The PHY is never powered up while the PLL is down. The reset request is released only with both sections powered up. The load strobes are one-hot and come in a fixed order. Latched codes are always in range, the sample count stays bounded, and `done` and `err` never pulse together. The scenarios are needed to show the rest: the exact sampling cadence, the timeout after the full number of samples, the command priority, the rejection of out-of-range dividers at each limit, and that commands arriving while busy leave the outputs untouched.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int TICKS_PER_POLL = 10,
  parameter int MAX_POLLS      = 100,
  parameter int CM_W           = 9,
  parameter int CN_W           = 6,
  parameter int CO_W           = 4,
  parameter int CM_MIN         = 16,
  parameter int CM_MAX         = 255,
  parameter int CN_MIN         = 1,
  parameter int CN_MAX         = 32,
  parameter int CO_MIN         = 1,
  parameter int CO_MAX         = 8,
  parameter logic [7:0] TEST_CODE = 8'h25,
  localparam int AW = $clog2(MAX_POLLS + 1),
  localparam int TW = (TICKS_PER_POLL > 1) ? $clog2(TICKS_PER_POLL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic            cmd_init,
  input  logic            cmd_on,
  input  logic            cmd_off,
  input  logic            cmd_exit,
  input  logic            pll_lock,
  input  logic [CM_W-1:0] cm_in,
  input  logic [CN_W-1:0] cn_in,
  input  logic [CO_W-1:0] co_in,
  output logic            pll_pd,
  output logic            phy_pd,
  output logic            rst_release,
  output logic            ld_timing,
  output logic            ld_bypass_clr,
  output logic            ld_test,
  output logic [7:0]      test_value,
  output logic            ld_div,
  output logic [CM_W-1:0] cm_code,
  output logic [CN_W-1:0] cn_code,
  output logic [CO_W-1:0] co_code,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [AW-1:0]   attempts
);

  typedef enum logic [2:0] {
    S_IDLE, S_TIM, S_BYP, S_TST, S_DIV, S_POLL, S_REL
  } state_t;

  state_t        state;
  logic [TW-1:0] tcnt;
  logic          div_ok;

  assign div_ok = (cm_in >= CM_W'(CM_MIN)) && (cm_in <= CM_W'(CM_MAX)) &&
                  (cn_in >= CN_W'(CN_MIN)) && (cn_in <= CN_W'(CN_MAX)) &&
                  (co_in >= CO_W'(CO_MIN)) && (co_in <= CO_W'(CO_MAX));

  assign busy          = (state != S_IDLE);
  assign ld_timing     = (state == S_TIM);
  assign ld_bypass_clr = (state == S_BYP);
  assign ld_test       = (state == S_TST);
  assign ld_div        = (state == S_DIV) && div_ok;
  assign test_value    = TEST_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      pll_pd      <= 1'b1;
      phy_pd      <= 1'b1;
      rst_release <= 1'b0;
      cm_code     <= '0;
      cn_code     <= '0;
      co_code     <= '0;
      attempts    <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_off) begin
            pll_pd      <= 1'b1;
            phy_pd      <= 1'b1;
            rst_release <= 1'b0;
            done        <= 1'b1;
          end else if (cmd_init) begin
            pll_pd      <= 1'b1;
            phy_pd      <= 1'b1;
            rst_release <= 1'b0;
            state       <= S_TIM;
          end else if (cmd_on) begin
            pll_pd   <= 1'b0;
            attempts <= '0;
            tcnt     <= '0;
            state    <= S_POLL;
          end else if (cmd_exit) begin
            cm_code <= '0;
            cn_code <= '0;
            co_code <= '0;
            done    <= 1'b1;
          end
        end
        S_TIM: state <= S_BYP;
        S_BYP: state <= S_TST;
        S_TST: state <= S_DIV;
        S_DIV: begin
          if (div_ok) begin
            cm_code <= cm_in;
            cn_code <= cn_in;
            co_code <= co_in;
            done    <= 1'b1;
          end else begin
            err <= 1'b1;
          end
          state <= S_IDLE;
        end
        S_POLL: begin
          if (us_tick) begin
            if (tcnt == TW'(TICKS_PER_POLL - 1)) begin
              tcnt     <= '0;
              attempts <= attempts + 1'b1;
              if (pll_lock) begin
                phy_pd <= 1'b0;
                state  <= S_REL;
              end else if (attempts == AW'(MAX_POLLS - 1)) begin
                pll_pd <= 1'b1;
                err    <= 1'b1;
                state  <= S_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_REL: begin
          rst_release <= 1'b1;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwr_seq_sva.sv
module phy_pwr_seq_sva #(
  parameter int CM_W = 9,
  parameter int CM_MIN = 16,
  parameter int CM_MAX = 255,
  parameter int MAX_POLLS = 100,
  parameter int AW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_off,
  input logic            pll_pd,
  input logic            phy_pd,
  input logic            rst_release,
  input logic            ld_timing,
  input logic            ld_bypass_clr,
  input logic            ld_test,
  input logic            ld_div,
  input logic [CM_W-1:0] cm_code,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [AW-1:0]   attempts
);

  assert_phy_needs_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_pd |-> !pll_pd);

  assert_release_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |-> (!phy_pd && !pll_pd));

  assert_off_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_off && !busy) |=> (pll_pd && phy_pd && !rst_release && done));

  assert_strobes_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_timing, ld_bypass_clr, ld_test, ld_div}));

  assert_bypass_after_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_bypass_clr |-> $past(ld_timing));

  assert_test_after_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_test |-> $past(ld_bypass_clr));

  assert_code_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cm_code) && cm_code != '0) |->
      (cm_code >= CM_W'(CM_MIN) && cm_code <= CM_W'(CM_MAX)));

  assert_pll_on_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pd) |-> busy);

  assert_err_leaves_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pll_pd && phy_pd));

  assert_attempts_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= AW'(MAX_POLLS));

  assert_done_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

endmodule

bind phy_pwr_seq phy_pwr_seq_sva #(
  .CM_W(CM_W), .CM_MIN(CM_MIN), .CM_MAX(CM_MAX), .MAX_POLLS(MAX_POLLS), .AW(AW)
) sva_i (
  .clk(clk), .rst_n(rst_n), .cmd_off(cmd_off), .pll_pd(pll_pd), .phy_pd(phy_pd),
  .rst_release(rst_release), .ld_timing(ld_timing), .ld_bypass_clr(ld_bypass_clr),
  .ld_test(ld_test), .ld_div(ld_div), .cm_code(cm_code), .busy(busy),
  .done(done), .err(err), .attempts(attempts)
);

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic cmd_init = 1'b0, cmd_on = 1'b0, cmd_off = 1'b0, cmd_exit = 1'b0;
  logic pll_lock = 1'b0;
  logic [8:0] cm_in = '0;
  logic [5:0] cn_in = '0;
  logic [3:0] co_in = '0;
  logic pll_pd, phy_pd, rst_release, ld_timing, ld_bypass_clr, ld_test, ld_div;
  logic [7:0] test_value;
  logic [8:0] cm_code;
  logic [5:0] cn_code;
  logic [3:0] co_code;
  logic busy, done, err;
  logic [6:0] attempts;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int err_seen = 0;
  int done_seen = 0;

  always #2.5 clk = ~clk;

  phy_pwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_init(cmd_init),
    .cmd_on(cmd_on), .cmd_off(cmd_off), .cmd_exit(cmd_exit), .pll_lock(pll_lock),
    .cm_in(cm_in), .cn_in(cn_in), .co_in(co_in), .pll_pd(pll_pd), .phy_pd(phy_pd),
    .rst_release(rst_release), .ld_timing(ld_timing), .ld_bypass_clr(ld_bypass_clr),
    .ld_test(ld_test), .test_value(test_value), .ld_div(ld_div), .cm_code(cm_code),
    .cn_code(cn_code), .co_code(co_code), .busy(busy), .done(done), .err(err),
    .attempts(attempts)
  );

  // reference model: phase 0 idle, 1..3 load strobes, 4 divider check, 5 sampling, 6 release
  int ph, tc, m_att, m_cm, m_cn, m_co;
  bit m_pll, m_phy, m_rel, m_done, m_err;

  function automatic bit div_valid(int cm, int cn, int co);
    return cm >= 16 && cm <= 255 && cn >= 1 && cn <= 32 && co >= 1 && co <= 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; tc <= 0; m_att <= 0; m_cm <= 0; m_cn <= 0; m_co <= 0;
      m_pll <= 1; m_phy <= 1; m_rel <= 0; m_done <= 0; m_err <= 0;
    end else begin
      m_done <= 0; m_err <= 0;
      if (ph == 0) begin
        if (cmd_off) begin m_pll <= 1; m_phy <= 1; m_rel <= 0; m_done <= 1; end
        else if (cmd_init) begin m_pll <= 1; m_phy <= 1; m_rel <= 0; ph <= 1; end
        else if (cmd_on) begin m_pll <= 0; m_att <= 0; tc <= 0; ph <= 5; end
        else if (cmd_exit) begin m_cm <= 0; m_cn <= 0; m_co <= 0; m_done <= 1; end
      end else if (ph < 4) ph <= ph + 1;
      else if (ph == 4) begin
        if (div_valid(cm_in, cn_in, co_in)) begin
          m_cm <= cm_in; m_cn <= cn_in; m_co <= co_in; m_done <= 1;
        end else m_err <= 1;
        ph <= 0;
      end else if (ph == 5) begin
        if (us_tick) begin
          if (tc == 9) begin
            tc <= 0; m_att <= m_att + 1;
            if (pll_lock) begin m_phy <= 0; ph <= 6; end
            else if (m_att + 1 == 100) begin m_pll <= 1; m_err <= 1; ph <= 0; end
          end else tc <= tc + 1;
        end
      end else begin
        m_rel <= 1; m_done <= 1; ph <= 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (err) err_seen++;
    if (done) done_seen++;
    chk("R1 R5 R7 pll_pd", pll_pd, m_pll);
    chk("R6 R7 phy_pd", phy_pd, m_phy);
    chk("R6 R7 rst_release", rst_release, m_rel);
    chk("R2 ld_timing", ld_timing, ph == 1);
    chk("R2 ld_bypass_clr", ld_bypass_clr, ph == 2);
    chk("R2 ld_test", ld_test, ph == 3);
    chk("R2 test_value", test_value, 8'h25);
    chk("R3 ld_div", ld_div, ph == 4 && div_valid(cm_in, cn_in, co_in));
    chk("R3 R8 cm_code", cm_code, m_cm);
    chk("R3 R8 cn_code", cn_code, m_cn);
    chk("R3 R8 co_code", co_code, m_co);
    chk("R9 busy", busy, ph != 0);
    chk("R3 R6 done", done, m_done);
    chk("R3 R5 err", err, m_err);
    chk("R4 R11 attempts", attempts, m_att);
  end

  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 3;
    us_tick <= (tick_div == 0);
  end

  task automatic pulse(bit i, bit o, bit f, bit x);
    @(negedge clk);
    cmd_init = i; cmd_on = o; cmd_off = f; cmd_exit = x;
    @(negedge clk);
    cmd_init = 0; cmd_on = 0; cmd_off = 0; cmd_exit = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_init(int cm, int cn, int co);
    cm_in = 9'(cm); cn_in = 6'(cn); co_in = 4'(co);
    pulse(1, 0, 0, 0);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pll_pd", pll_pd, 1);
    chk("R1 reset busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    do_init(100, 2, 4);
    chk("R3 valid codes latched", cm_code, 100);
    do_init(16, 1, 1);
    do_init(255, 32, 8);
    chk("R3 upper bounds latched", cn_code, 32);
    err_seen = 0;
    do_init(15, 2, 2);
    do_init(256, 2, 2);
    do_init(100, 0, 2);
    do_init(100, 33, 2);
    do_init(100, 2, 0);
    do_init(100, 2, 9);
    chk("R3 six rejected dividers", err_seen, 6);
    chk("R3 codes kept after reject", cm_code, 255);

    pll_lock = 1;
    pulse(0, 1, 0, 0);
    wait_idle();
    chk("R11 lock at first sample", attempts, 1);
    chk("R6 reset released", rst_release, 1);

    pulse(0, 0, 1, 0);
    wait_idle();
    chk("R7 power-down pll", pll_pd, 1);

    pll_lock = 0;
    pulse(0, 1, 0, 0);
    repeat (100) @(negedge clk);
    pulse(1, 0, 1, 1);
    repeat (5) @(negedge clk);
    pll_lock = 1;
    wait_idle();
    chk("R9 busy commands ignored, then lock", rst_release, 1);

    pulse(0, 0, 1, 0);
    wait_idle();
    pll_lock = 0;
    err_seen = 0;
    pulse(0, 1, 0, 0);
    wait_idle();
    chk("R5 timeout attempts", attempts, 100);
    chk("R5 timeout error pulse", err_seen, 1);
    chk("R5 pll back off", pll_pd, 1);

    cm_in = 9'd50; cn_in = 6'd4; co_in = 4'd2;
    pulse(1, 1, 1, 1);
    wait_idle();
    chk("R10 off wins", busy, 0);
    pulse(1, 1, 0, 1);
    wait_idle();
    chk("R10 init wins over on", cm_code, 50);
    pulse(0, 1, 0, 1);
    wait_idle();
    chk("R10 on wins over exit", cm_code, 50);
    pulse(0, 0, 0, 1);
    wait_idle();
    chk("R8 exit clears cm", cm_code, 0);
    chk("R8 exit clears co", co_code, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R9: actual busy %0d expected 0", busy);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule